// File: doc/BRIEF.md
# Video Free-Run Override Stage

This stage sits on a 4:2:2 pixel path. Each pixel has an 8-bit luma sample and one chroma sample, with a flag that says whether the chroma is Cr or Cb. The stage adds a signed brightness offset to luma and clamps the result to the video range. It then outputs either the adjusted pixel or a programmed default colour, which is the free-run output used when the upstream decoder has no usable picture.

Three configuration inputs set the free-run behaviour. A force bit turns the override on unconditionally. An automatic bit turns it on only while the upstream lock indicator is low. With both bits clear the override is off. The default colour comes from two short fields: a 6-bit luma field and a byte that holds the Cr value in its upper half and the Cb value in its lower half. Both fields are zero-padded at the bottom to full 8-bit samples. A change of override state takes effect only on a line-start strobe, so a line is never partly replaced. A status output shows whether the registered pixel now on the outputs is the default colour.

Top module: `vid_freerun_stage`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `freerun_active`, `out_y`, `out_c` and `out_c_is_cr` are all 0.
- R2: Outputs are registered with a latency of one clock. `out_valid` and `out_c_is_cr` follow `in_valid` and `in_c_is_cr` from the previous cycle.
- R3: In normal mode, `out_y` equals `in_y` plus `cfg_bright` read as two's complement (0x00 adds nothing, 0x7F adds +127, 0x80 adds -128), provided the sum lies within 16..235.
- R4: In normal mode, a luma sum below 16 gives 16 and a sum above 235 gives 235.
- R5: In normal mode, `out_c` equals `in_c` unchanged, whatever the brightness setting.
- R6: If `cfg_force` = 1 at a line-start strobe, the following line is in free-run, whatever the value of `lock_ok`.
- R7: If `cfg_force` = 0 and `cfg_auto` = 1 at a line-start strobe, the following line is in free-run exactly when `lock_ok` = 0.
- R8: If `cfg_force` = 0 and `cfg_auto` = 0 at a line-start strobe, the following line is in normal mode.
- R9: In free-run, `out_y` = {`cfg_def_y`[5:0], 2'b00}.
- R10: In free-run, `out_c` = {`cfg_def_c`[7:4], 4'b0000} for a sample with `in_c_is_cr` = 1 (Cr). It is {`cfg_def_c`[3:0], 4'b0000} for a sample with `in_c_is_cr` = 0 (Cb).
- R11: The mode is sampled only in the cycle where `in_line_start` = 1, and that pixel already uses the new mode. Changes to `cfg_force`, `cfg_auto` or `lock_ok` on other cycles do not affect the outputs until the next strobe.
- R12: `freerun_active` is 1 exactly when the pixel on the outputs was produced in free-run mode. It changes only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_y | input | 8 | Input luma |
| in_c | input | 8 | Input chroma sample |
| in_c_is_cr | input | 1 | 1 = chroma is Cr, 0 = Cb |
| in_line_start | input | 1 | Line boundary strobe; mode is sampled here |
| lock_ok | input | 1 | Upstream lock indicator |
| cfg_bright | input | 8 | Two's-complement luma offset |
| cfg_def_y | input | 6 | Default luma field |
| cfg_def_c | input | 8 | Default chroma field (Cr high nibble, Cb low nibble) |
| cfg_force | input | 1 | Force free-run |
| cfg_auto | input | 1 | Free-run automatically while unlocked |
| out_valid | output | 1 | Output pixel valid |
| out_y | output | 8 | Output luma |
| out_c | output | 8 | Output chroma |
| out_c_is_cr | output | 1 | Delayed chroma select |
| freerun_active | output | 1 | Output pixel is the default colour |

## Verification
The stage holds only one piece of state beyond its output register: the latched mode. If that latch goes wrong, a whole line shows at the ports with the wrong colour source, and `freerun_active` disagrees with the data from the next clock onward. Mid-line changes to the configuration are applied to show that the latch ignores them until the strobe. The luma path has no state, so a wrong clamp or sign extension shows up on the very next output sample. Brightness values at both extremes drive that check.

// File: rtl/vid_freerun_stage.sv
module vid_freerun_stage #(
  parameter int W        = 8,
  parameter int LUMA_MIN = 16,
  parameter int LUMA_MAX = 235
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_c,
  input  logic         in_c_is_cr,
  input  logic         in_line_start,
  input  logic         lock_ok,
  input  logic [W-1:0] cfg_bright,
  input  logic [W-3:0] cfg_def_y,
  input  logic [W-1:0] cfg_def_c,
  input  logic         cfg_force,
  input  logic         cfg_auto,
  output logic         out_valid,
  output logic [W-1:0] out_y,
  output logic [W-1:0] out_c,
  output logic         out_c_is_cr,
  output logic         freerun_active
);
  localparam int HW = W / 2;
  localparam logic signed [W+1:0] S_LO = (W+2)'(LUMA_MIN);
  localparam logic signed [W+1:0] S_HI = (W+2)'(LUMA_MAX);

  logic signed [W+1:0] sum;
  logic [W-1:0] y_adj, y_def, c_def;
  logic want, fr_q, eff;

  assign sum   = $signed({2'b00, in_y}) + $signed({{2{cfg_bright[W-1]}}, cfg_bright});
  assign y_adj = (sum < S_LO) ? S_LO[W-1:0] : (sum > S_HI) ? S_HI[W-1:0] : sum[W-1:0];
  assign y_def = {cfg_def_y, 2'b00};
  assign c_def = in_c_is_cr ? {cfg_def_c[W-1:HW], {HW{1'b0}}} : {cfg_def_c[HW-1:0], {HW{1'b0}}};

  assign want = cfg_force | (cfg_auto & ~lock_ok);
  assign eff  = in_line_start ? want : fr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q        <= 1'b0;
      out_valid   <= 1'b0;
      out_y       <= '0;
      out_c       <= '0;
      out_c_is_cr <= 1'b0;
    end else begin
      fr_q        <= eff;
      out_valid   <= in_valid;
      out_y       <= eff ? y_def : y_adj;
      out_c       <= eff ? c_def : in_c;
      out_c_is_cr <= in_c_is_cr;
    end
  end

  assign freerun_active = fr_q;
endmodule

// File: rtl/vid_freerun_stage_chk.sv
module vid_freerun_stage_chk #(
  parameter int W        = 8,
  parameter int LUMA_MIN = 16,
  parameter int LUMA_MAX = 235
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_c_is_cr,
  input logic         in_line_start,
  input logic         lock_ok,
  input logic [W-3:0] cfg_def_y,
  input logic         cfg_force,
  input logic         cfg_auto,
  input logic         out_valid,
  input logic [W-1:0] out_y,
  input logic         out_c_is_cr,
  input logic         freerun_active
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= rst_n;

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid) && out_c_is_cr == $past(in_c_is_cr)));

  p_luma_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !freerun_active) |-> (int'(out_y) >= LUMA_MIN && int'(out_y) <= LUMA_MAX));

  p_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_line_start && cfg_force)) |-> freerun_active);

  p_auto_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_line_start && !cfg_force && cfg_auto)) |-> (freerun_active == !$past(lock_ok)));

  p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_line_start && !cfg_force && !cfg_auto)) |-> !freerun_active);

  p_def_luma_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && freerun_active) |-> (out_y == {$past(cfg_def_y), 2'b00}));

  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(in_line_start)) |-> $stable(freerun_active));
endmodule

bind vid_freerun_stage vid_freerun_stage_chk #(.W(W), .LUMA_MIN(LUMA_MIN), .LUMA_MAX(LUMA_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_c_is_cr(in_c_is_cr),
  .in_line_start(in_line_start), .lock_ok(lock_ok), .cfg_def_y(cfg_def_y),
  .cfg_force(cfg_force), .cfg_auto(cfg_auto), .out_valid(out_valid), .out_y(out_y),
  .out_c_is_cr(out_c_is_cr), .freerun_active(freerun_active)
);

// File: tb/vid_freerun_stage_test.sv
module vid_freerun_stage_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_c_is_cr = 1'b0, in_line_start = 1'b0, lock_ok = 1'b1;
  logic [7:0] in_y = '0, in_c = '0, cfg_bright = '0, cfg_def_c = 8'h7E;
  logic [5:0] cfg_def_y = 6'h04;
  logic cfg_force = 1'b0, cfg_auto = 1'b0;
  logic out_valid, out_c_is_cr, freerun_active;
  logic [7:0] out_y, out_c;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  vid_freerun_stage uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_y(in_y), .in_c(in_c),
    .in_c_is_cr(in_c_is_cr), .in_line_start(in_line_start), .lock_ok(lock_ok),
    .cfg_bright(cfg_bright), .cfg_def_y(cfg_def_y), .cfg_def_c(cfg_def_c),
    .cfg_force(cfg_force), .cfg_auto(cfg_auto), .out_valid(out_valid), .out_y(out_y),
    .out_c(out_c), .out_c_is_cr(out_c_is_cr), .freerun_active(freerun_active)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int luma_exp(input int y, input int b);
    int s = y + ((b >= 128) ? b - 256 : b);
    if (s < 16) return 16;
    if (s > 235) return 235;
    return s;
  endfunction

  // drive one pixel at the falling edge, sample just after the capturing edge
  task automatic pix(input int y, input int c, input bit cr, input bit ls);
    @(negedge clk);
    in_valid = 1'b1; in_y = 8'(y); in_c = 8'(c); in_c_is_cr = cr; in_line_start = ls;
    @(posedge clk); #1;
    in_line_start = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 valid", out_valid, 0);
    chk("R1 active", freerun_active, 0);
    chk("R1 y", out_y, 0);
    chk("R1 c", out_c, 0);
    chk("R1 sel", out_c_is_cr, 0);
  endtask

  task automatic t_latency;
    pix(100, 60, 1'b1, 1'b1);
    chk("R2 valid", out_valid, 1);
    chk("R2 sel", out_c_is_cr, 1);
    @(negedge clk); in_valid = 1'b0; in_c_is_cr = 1'b0;
    @(posedge clk); #1;
    chk("R2 valid low", out_valid, 0);
    chk("R2 sel low", out_c_is_cr, 0);
  endtask

  task automatic t_bright;
    int ys[6] = '{100, 120, 30, 200, 16, 235};
    int bs[6] = '{0, 8'h10, 8'hF0, 8'h7F, 8'h80, 8'h01};
    cfg_force = 0; cfg_auto = 0;
    foreach (ys[i]) begin
      cfg_bright = 8'(bs[i]);
      pix(ys[i], 77, i % 2, i == 0);
      chk((luma_exp(ys[i], bs[i]) == ys[i] + ((bs[i] >= 128) ? bs[i] - 256 : bs[i])) ? "R3 luma" : "R4 clamp",
          out_y, luma_exp(ys[i], bs[i]));
      chk("R5 chroma", out_c, 77);
      chk("R8 normal", freerun_active, 0);
    end
    cfg_bright = 8'h80; pix(10, 5, 0, 0);
    chk("R4 low clamp", out_y, 16);
    cfg_bright = 8'h7F; pix(250, 200, 1, 0);
    chk("R4 high clamp", out_y, 235);
    chk("R5 chroma", out_c, 200);
    cfg_bright = 0;
  endtask

  task automatic t_force;
    cfg_force = 1; cfg_auto = 0; lock_ok = 1; cfg_def_y = 6'h2A; cfg_def_c = 8'hC3;
    pix(100, 50, 1, 1);
    chk("R6 active", freerun_active, 1);
    chk("R9 def y", out_y, 8'hA8);
    chk("R10 def cr", out_c, 8'hC0);
    pix(100, 50, 0, 0);
    chk("R10 def cb", out_c, 8'h30);
    chk("R12 active", freerun_active, 1);
  endtask

  task automatic t_auto;
    cfg_force = 0; cfg_auto = 1; lock_ok = 0; cfg_def_y = 6'h04; cfg_def_c = 8'h7E;
    pix(90, 40, 0, 1);
    chk("R7 unlocked", freerun_active, 1);
    chk("R10 blue cb", out_c, 8'hE0);
    chk("R9 blue y", out_y, 16);
    lock_ok = 1;
    pix(90, 40, 0, 1);
    chk("R7 locked", freerun_active, 0);
    chk("R12 data", out_y, 90);
  endtask

  task automatic t_off;
    cfg_force = 0; cfg_auto = 0; lock_ok = 0;
    pix(60, 33, 1, 1);
    chk("R8 off", freerun_active, 0);
    chk("R8 data", out_y, 60);
    lock_ok = 1;
  endtask

  task automatic t_midline;
    cfg_force = 0; cfg_auto = 0; cfg_def_y = 6'h30; cfg_def_c = 8'h55;
    pix(80, 90, 0, 1);
    cfg_force = 1;
    for (int k = 0; k < 3; k++) begin
      pix(80 + k, 90, k % 2, 0);
      chk("R11 held y", out_y, 80 + k);
      chk("R11 held flag", freerun_active, 0);
    end
    pix(80, 90, 1, 1);
    chk("R11 switch", freerun_active, 1);
    chk("R11 switch y", out_y, 8'hC0);
    cfg_force = 0;
    pix(80, 90, 1, 0);
    chk("R11 hold on", out_c, 8'h50);
    pix(80, 90, 1, 1);
    chk("R12 back", freerun_active, 0);
    chk("R12 back c", out_c, 90);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    pix(50, 50, 1, 1);
    t_reset();
    @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;
    t_latency();
    t_bright();
    t_force();
    t_auto();
    t_off();
    t_midline();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule